// File: doc/BRIEF.md
# Edge-Triggered Input Latch with Interrupt

This block watches a parallel digital input word and freezes a copy of it when a chosen transition appears on one of its own input lines, the request line. A control register picks the transition (rising or falling) or turns capture off. When capture is off, the data register simply follows the synchronized input. Each recognised event sets a pending flag. The interrupt output follows that flag when the interrupt enable is set. Two further flags record which edge polarity caused the event. A sticky missed flag records that an event arrived while an earlier one was still pending.

A second input line acts as an active-low arm pin: while it is high, request edges are not recognised. Both the request and arm lines can still be read as ordinary inputs through the live-input register. Both are forced to zero in the captured word. The whole input word passes through a two-flop synchronizer. A request transition therefore becomes an event on the third clock edge after it appears at the pin.

Software works through a small word-addressed register port. Reads are combinational. Writes take effect on the clock edge. Status bits are cleared by writing ones to them.

Top module: `edge_capture_irq`

## Requirements
- R1: After synchronous reset, the control register reads 0, the status register reads 0, the data register reads 0, and `irq_o` is low.
- R2: The control register is at address 0. Bits [1:0] select the mode: 01 captures on rising request edges, 10 captures on falling request edges, 00 and 11 mean capture off. Bit 2 is the interrupt enable. A read returns the written value in bits [2:0] and zero above.
- R3: While capture is off, no status bit is ever set. The data register (address 2) follows the synchronized input with bits 6 and 7 forced to zero. A pin value appears there after the third clock edge following its application.
- R4: In a capture mode, a selected edge on input bit 6 (the request line) has the following effect on the third clock edge after it appears at the pin. The data register loads the synchronized input word with bits 6 and 7 forced to zero, and the pending bit (status bit 0) is set.
- R5: While input bit 7 (the active-low arm line) is high, request edges are not recognised: no status bit changes and the data register keeps its value.
- R6: In a capture mode, the data register holds its captured value across input changes until the next qualifying edge.
- R7: A qualifying edge that arrives while pending is set re-captures the data and sets the missed bit (status bit 1).
- R8: The missed bit is sticky: further misses leave it at 1, and only a software clear resets it.
- R9: A rising-edge event sets status bit 2. A falling-edge event sets status bit 3.
- R10: `irq_o` is high exactly when the pending bit and the interrupt enable are both set.
- R11: Writing to the status register (address 1) clears each status bit whose data bit is 1. Zeros leave bits unchanged. A clear wins over a set on the same edge.
- R12: Address 3 reads the live synchronized input word, including bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | DATA_W | Parallel input word. Bit 6 is the request line, bit 7 the active-low arm line |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data, 3 live input |
| wr_data_i | input | 4 | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the in-line properties check the following:
- capture-off mode never produces an event;
- a high arm line blocks recognition;
- an event sets pending, and the matching polarity bit;
- an event that meets a pending flag sets the missed bit, which stays set until cleared;
- the captured word is stable between events;
- a pending clear always wins.

The exact three-edge latency, the masking of bits 6 and 7, the register encodings, and the clear-versus-set collision on a single edge can only be shown by the bench. It drives timed scenarios against a behavioural model and compares every read and the interrupt line on every clock.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

    typedef enum logic [1:0] {
        LM_OFF  = 2'b00,
        LM_RISE = 2'b01,
        LM_FALL = 2'b10,
        LM_IDLE = 2'b11
    } lmode_e;

    typedef struct packed {
        logic   ien;
        lmode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic fell;
        logic rose;
        logic miss;
        logic pend;
    } stat_t;

    typedef struct packed {
        logic hit;
        logic rising;
    } evt_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_LIVE = 2'd3;

    function automatic logic mode_latching(lmode_e m);
        return (m == LM_RISE) || (m == LM_FALL);
    endfunction

endpackage

// File: rtl/ecl_sync.sv
module ecl_sync
    import ecl_pkg::*;
#(
    parameter int W       = 8,
    parameter int REQ_BIT = 6,
    parameter int ENA_BIT = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  lmode_e       mode_i,
    output logic [W-1:0] live_o,
    output logic [W-1:0] cap_o,
    output evt_t         evt_o
);
    logic [W-1:0] s1_q, s2_q;
    logic         req_prev_q;
    logic         rise, fall, armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q       <= '0;
            s2_q       <= '0;
            req_prev_q <= 1'b0;
        end else begin
            s1_q       <= pin_i;
            s2_q       <= s1_q;
            req_prev_q <= s2_q[REQ_BIT];
        end
    end

    assign rise  =  s2_q[REQ_BIT] & ~req_prev_q;
    assign fall  = ~s2_q[REQ_BIT] &  req_prev_q;
    assign armed = ~s2_q[ENA_BIT];

    always_comb begin
        evt_o.rising = (mode_i == LM_RISE);
        evt_o.hit    = armed & (((mode_i == LM_RISE) & rise) |
                                ((mode_i == LM_FALL) & fall));
    end

    assign live_o = s2_q;

    for (genvar i = 0; i < W; i++) begin : g_mask
        if (i == REQ_BIT || i == ENA_BIT) begin : g_ctl
            assign cap_o[i] = 1'b0;
        end else begin : g_dat
            assign cap_o[i] = s2_q[i];
        end
    end

    // R5
    arm_block_chk: assert property (@(posedge clk) disable iff (rst)
        s2_q[ENA_BIT] |-> !evt_o.hit);

endmodule

// File: rtl/ecl_capture.sv
module ecl_capture
    import ecl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt_i,
    input  lmode_e       mode_i,
    input  logic [W-1:0] cap_i,
    input  stat_t        clr_i,
    output logic [W-1:0] latch_o,
    output stat_t        stat_o
);
    logic [W-1:0] latch_q;
    stat_t        stat_q, set_v, stat_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (!mode_latching(mode_i) || evt_i.hit) begin
            latch_q <= cap_i;
        end
    end

    always_comb begin
        set_v.pend = evt_i.hit;
        set_v.miss = evt_i.hit & stat_q.pend;
        set_v.rose = evt_i.hit &  evt_i.rising;
        set_v.fell = evt_i.hit & ~evt_i.rising;
        stat_d     = (stat_q | set_v) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign latch_o = latch_q;
    assign stat_o  = stat_q;

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.hit && !clr_i.pend) |=> stat_q.pend);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_latching(mode_i) && !evt_i.hit) |=> $stable(latch_q));
    // R7
    miss_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.hit && stat_q.pend && !clr_i.miss) |=> stat_q.miss);
    // R8
    miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.miss && !clr_i.miss) |=> stat_q.miss);
    // R9
    rose_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.hit && evt_i.rising && !clr_i.rose) |=> stat_q.rose);
    // R11
    clr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i.pend |=> !stat_q.pend);

endmodule

// File: rtl/edge_capture_irq.sv
module edge_capture_irq
    import ecl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REQ_BIT = 6,
    parameter int ENA_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pin_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [3:0]        wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

    ctrl_t             ctrl_q;
    stat_t             stat, clr;
    evt_t              evt;
    logic [DATA_W-1:0] live, cap, latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en_i && addr_i == ADR_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    assign clr = (wr_en_i && addr_i == ADR_STAT) ? stat_t'(wr_data_i[STAT_W-1:0]) : '0;

    ecl_sync #(.W(DATA_W), .REQ_BIT(REQ_BIT), .ENA_BIT(ENA_BIT)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .mode_i (ctrl_q.mode),
        .live_o (live),
        .cap_o  (cap),
        .evt_o  (evt)
    );

    ecl_capture #(.W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .mode_i  (ctrl_q.mode),
        .cap_i   (cap),
        .clr_i   (clr),
        .latch_o (latch),
        .stat_o  (stat)
    );

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            ADR_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_q;
            ADR_STAT: rd_data_o[STAT_W-1:0] = stat;
            ADR_DATA: rd_data_o             = latch;
            default:  rd_data_o             = live;
        endcase
    end

    assign irq_o = stat.pend & ctrl_q.ien;

    // R3
    off_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_latching(ctrl_q.mode) |-> !evt.hit);

endmodule

// File: tb/edge_capture_irq_tb.sv
`timescale 1ns/1ps
module edge_capture_irq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] wr_data = 4'h0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    edge_capture_irq u_dut (
        .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
    );

    // behavioural reference
    logic [7:0] hist[$];
    logic [1:0] m_mode;
    logic       m_ien, m_pend, m_miss, m_rose, m_fell;
    logic [7:0] m_lat;

    initial hist = '{8'h00, 8'h00, 8'h00};

    always @(posedge clk) begin
        logic [7:0] cur, old;
        logic       hit;
        logic [3:0] clr;
        if (rst) begin
            hist = '{8'h00, 8'h00, 8'h00};
            m_mode = 0; m_ien = 0; m_lat = 0;
            m_pend = 0; m_miss = 0; m_rose = 0; m_fell = 0;
        end else begin
            cur = hist[1];
            old = hist[0];
            hit = 0;
            if (!cur[7]) begin
                if (m_mode == 2'b01 && cur[6] && !old[6]) hit = 1;
                if (m_mode == 2'b10 && !cur[6] && old[6]) hit = 1;
            end
            if (hit || !(m_mode == 2'b01 || m_mode == 2'b10)) m_lat = cur & 8'h3F;
            if (hit) begin
                if (m_pend) m_miss = 1;
                m_pend = 1;
                if (m_mode == 2'b01) m_rose = 1; else m_fell = 1;
            end
            clr = (wr_en && addr == 2'd1) ? wr_data : 4'h0;
            if (clr[0]) m_pend = 0;
            if (clr[1]) m_miss = 0;
            if (clr[2]) m_rose = 0;
            if (clr[3]) m_fell = 0;
            if (wr_en && addr == 2'd0) {m_ien, m_mode} = wr_data[2:0];
            hist.push_back(pin);
            void'(hist.pop_front());
        end
    end

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return {5'b0, m_ien, m_mode};
            2'd1:    return {4'b0, m_fell, m_rose, m_miss, m_pend};
            2'd2:    return m_lat;
            default: return hist[1];
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            case (addr)
                2'd0: check("R2 model ctrl", rd_data, model_read(2'd0));
                2'd1: check("R9 model status", rd_data, model_read(2'd1));
                2'd2: check("R4 model data", rd_data, model_read(2'd2));
                default: check("R12 model live", rd_data, model_read(2'd3));
            endcase
            check("R10 model irq", {7'b0, irq}, {7'b0, m_pend & m_ien});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [1:0] a, logic [3:0] d);
        wr_en = 1; addr = a; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        addr = a;
        @(negedge clk); #1;
        check(tag, rd_data, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctrl after reset");
        rd(2'd1, 8'h00, "R1 status after reset");
        rd(2'd2, 8'h00, "R1 data after reset");
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R3 capture off: request toggles do nothing, data follows input
        pin = 8'h15; step(4);
        pin = 8'h55; step(4);
        pin = 8'h15; step(4);
        rd(2'd1, 8'h00, "R3 no status when off");
        rd(2'd2, 8'h15, "R3 transparent data");
        pin = 8'h55; step(3);
        rd(2'd2, 8'h15, "R3 bit 6 masked in data");

        // R2 / R4 / R9 / R10 rising capture with interrupt enabled
        pin = 8'h03; wr(2'd0, 4'h5); step(4);
        rd(2'd0, 8'h05, "R2 ctrl readback");
        pin = 8'h61; step(4);
        rd(2'd2, 8'h21, "R4 captured word");
        rd(2'd1, 8'h05, "R9 pending and rising set");
        check("R10 irq with enable", {7'b0, irq}, 8'h01);

        // R6 hold across input changes without a qualifying edge
        pin = 8'h1C; step(5);
        rd(2'd2, 8'h21, "R6 data held");
        rd(2'd1, 8'h05, "R6 status unchanged");

        // R7 miss while pending, R8 sticky on later misses
        pin = 8'h4E; step(4);
        rd(2'd2, 8'h0E, "R7 recaptured over pending");
        rd(2'd1, 8'h07, "R7 missed set");
        pin = 8'h0E; step(4);
        pin = 8'h73; step(4);
        rd(2'd2, 8'h33, "R8 recapture on second miss");
        rd(2'd1, 8'h07, "R8 missed stays set");

        // R11 write-one-to-clear
        wr(2'd1, 4'h2);
        rd(2'd1, 8'h05, "R11 only missed cleared");
        wr(2'd1, 4'hF);
        rd(2'd1, 8'h00, "R11 all cleared");
        check("R10 irq low after clear", {7'b0, irq}, 8'h00);

        // R5 arm line high blocks a rising edge
        pin = 8'h80; step(4);
        pin = 8'hD1; step(5);
        rd(2'd1, 8'h00, "R5 no event while disarmed");
        rd(2'd2, 8'h33, "R5 data unchanged while disarmed");
        pin = 8'h11; step(4);

        // R9 / R10 falling capture with interrupt disabled
        wr(2'd0, 4'h2);
        pin = 8'h45; step(4);
        pin = 8'h09; step(4);
        rd(2'd2, 8'h09, "R9 falling capture data");
        rd(2'd1, 8'h09, "R9 pending and falling set");
        check("R10 irq low when disabled", {7'b0, irq}, 8'h00);

        // R11 clear wins over a set on the same edge
        wr(2'd1, 4'hF);
        pin = 8'h45; step(4);
        pin = 8'h05; step(2);
        wr(2'd1, 4'h1);
        rd(2'd1, 8'h08, "R11 clear beats set");
        rd(2'd2, 8'h05, "R11 data still captured");

        // R12 live input, R2 mode 11 acts as off
        pin = 8'hC3; step(3);
        rd(2'd3, 8'hC3, "R12 live input with bits 6 and 7");
        wr(2'd0, 4'h3); step(3);
        rd(2'd2, 8'h03, "R2 mode 11 is transparent");
        rd(2'd0, 8'h03, "R2 ctrl readback 11");

        step(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule